// File: doc/BRIEF.md
# Compiled Four-Valued Gate Evaluator

This block is one processing unit of a logic-simulation engine. A compiler turns a gate-level subcircuit into a fixed list of gate entries, and the unit walks that list with a program counter, one gate per clock. It keeps no event queue. Every signal is held in a data memory as one of four states: 0, 1, unknown (X) or high impedance (Z). Each gate entry names a function, up to four source signals and one destination signal.

In every cycle the unit reads the entry at the program counter and fetches its operands. It forms an index from the function code and the operand values, looks the output value up in a precomputed table, and writes the value to the destination in the same clock edge. Because of this, a later gate in the same pass sees values that earlier gates have already written.

A host uses the unit in four steps. While the unit is idle, it writes gate entries and initial signal values through two write ports. It then pulses start with a gate count and waits for the single-cycle done pulse. Finally it reads any signal back through a combinational read port.

Top module: `gate_eval_unit`

## Requirements
- R1: After reset, busy and done are both low.
- R2: When start is sampled high while the unit is idle and gateCount is N>0, busy is high from the next cycle for exactly N cycles. Gate entries 0 to N-1 are evaluated in index order, one per cycle. Done is then high for exactly one cycle, in the cycle after the last gate result is written, so done is observed N clock edges after the start edge.
- R3: Signal values are 2 bits wide: 00 is 0, 01 is 1, 10 is X and 11 is Z. A Z on any used gate input is evaluated as X. A gate never produces Z.
- R4: The 4-bit function code decodes as follows. Bits [1:0] choose the base function: 0 is AND, 1 is OR, 2 is XOR and 3 is BUF. Bit 2 inverts the output. Bit 3 inverts source slot 0 before evaluation. Inverting X gives X.
- R5: AND gives 0 if any used input is 0, 1 if all used inputs are 1, and X otherwise. OR gives 1 if any used input is 1, 0 if all used inputs are 0, and X otherwise. XOR gives X if any used input is X, and the parity of the used inputs otherwise.
- R6: The 2-bit arity field gives the number of used inputs minus one. Slots above it take the non-controlling value of the base function (1 for AND, 0 for OR and XOR), so their addressed signals have no effect. BUF uses slot 0 only.
- R7: A result is written back in the same cycle it is computed, so a later gate in the same pass reads the updated value.
- R8: start with gateCount 0 evaluates no gate. Busy stays low, and done is high for one cycle starting one edge after the start edge.
- R9: While busy, host writes to either memory are ignored and start is ignored. The pass still ends after N gates, and neither the written-back values nor later passes change.
- R10: The read port returns the stored value at dataRdAddr combinationally. The gate entry is laid out as: source slot i at bits [12i+11:12i], destination at [59:48], arity at [61:60], function code at [65:62].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (sampled when idle) |
| gateCount | input | 13 | Number of gates to evaluate in the pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pass completion pulse |
| instWrEn | input | 1 | Gate entry write enable |
| instWrAddr | input | 12 | Gate entry write index |
| instWrData | input | 66 | Gate entry word |
| dataWrEn | input | 1 | Signal value write enable |
| dataWrAddr | input | 12 | Signal write address |
| dataWrData | input | 2 | Signal value to write |
| dataRdAddr | input | 12 | Signal read address |
| dataRdData | output | 2 | Signal value at dataRdAddr |

## Verification
The assertions assume that the host never asks for more gates than the gate memory holds and that it keeps start low except for single-cycle requests. The bench respects both. Every random pass uses a count between 1 and 40, destinations in a region apart from the reloaded inputs, and a start pulse one cycle wide. The single start issued during a pass is the deliberate probe for R9, and the checks accept it because it is sampled only while the unit is idle.

// File: rtl/gev_pkg.sv
package gev_pkg;

  typedef struct packed {
    logic evalEn;
    logic hostEn;
  } ctrl_strobe_t;

  localparam logic [1:0] SIG_LO  = 2'b00;
  localparam logic [1:0] SIG_HI  = 2'b01;
  localparam logic [1:0] SIG_UNK = 2'b10;
  localparam logic [1:0] SIG_HIZ = 2'b11;

  localparam int TERN_COMBOS = 81;
  localparam int FUNC_COUNT  = 16;

  function automatic logic [1:0] ternNot(input logic [1:0] v);
    if (v == SIG_LO) return SIG_HI;
    if (v == SIG_HI) return SIG_LO;
    return SIG_UNK;
  endfunction

  // Table entry for a flat index: code*81 + sum(digit_i * 3^i).
  function automatic logic [1:0] lutEntry(input int idx);
    int code;
    int rem;
    logic [1:0] t [4];
    logic anyLo, anyHi, anyUnk, par;
    logic [1:0] res;
    code = idx / TERN_COMBOS;
    rem  = idx % TERN_COMBOS;
    for (int i = 0; i < 4; i++) begin
      t[i] = 2'(rem % 3);
      rem  = rem / 3;
    end
    if ((code & 8) != 0) t[0] = ternNot(t[0]);
    anyLo = 1'b0; anyHi = 1'b0; anyUnk = 1'b0; par = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (t[i] == SIG_LO) anyLo = 1'b1;
      else if (t[i] == SIG_HI) begin anyHi = 1'b1; par = ~par; end
      else anyUnk = 1'b1;
    end
    case (code & 3)
      0: res = anyLo ? SIG_LO : (anyUnk ? SIG_UNK : SIG_HI);
      1: res = anyHi ? SIG_HI : (anyUnk ? SIG_UNK : SIG_LO);
      2: res = anyUnk ? SIG_UNK : {1'b0, par};
      default: res = t[0];
    endcase
    if ((code & 4) != 0) res = ternNot(res);
    return res;
  endfunction

endpackage

// File: rtl/gev_ctrl.sv
module gev_ctrl
  import gev_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W:0]   gateCount,
  output logic [ADDR_W-1:0] pc,
  output ctrl_strobe_t      strobe,
  output logic              busy,
  output logic              done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_e;

  seq_state_e        stateQ;
  logic [ADDR_W:0]   countQ;
  logic [ADDR_W-1:0] pcQ;
  logic              lastGate;

  assign lastGate = ({1'b0, pcQ} == (countQ - 1'b1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      countQ <= '0;
      pcQ    <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            countQ <= gateCount;
            pcQ    <= '0;
            stateQ <= (gateCount == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (lastGate) stateQ <= ST_FIN;
          else          pcQ    <= pcQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign pc            = pcQ;
  assign strobe.evalEn = (stateQ == ST_RUN);
  assign strobe.hostEn = (stateQ == ST_IDLE);
  assign busy          = (stateQ == ST_RUN);
  assign done          = (stateQ == ST_FIN);

endmodule

// File: rtl/gev_eval.sv
module gev_eval
  import gev_pkg::*;
(
  input  logic [3:0]      funcCode,
  input  logic [1:0]      arity,
  input  logic [3:0][1:0] opVals,
  output logic [1:0]      result
);

  localparam int LUT_SIZE  = FUNC_COUNT * TERN_COMBOS;
  localparam int LUT_IDX_W = $clog2(LUT_SIZE);

  logic [1:0] lutRom [LUT_SIZE];

  for (genvar g = 0; g < LUT_SIZE; g++) begin : gLut
    assign lutRom[g] = lutEntry(g);
  end

  logic [1:0] fillVal;
  logic [3:0][1:0] tern;
  int idxSum;

  always_comb begin
    fillVal = (funcCode[1:0] == 2'd0) ? SIG_HI : SIG_LO;
    for (int i = 0; i < 4; i++) begin
      if (i > int'(arity))           tern[i] = fillVal;
      else if (opVals[i] == SIG_HIZ) tern[i] = SIG_UNK;
      else                           tern[i] = opVals[i];
    end
    idxSum = int'(funcCode) * TERN_COMBOS
           + int'(tern[0]) + 3 * int'(tern[1])
           + 9 * int'(tern[2]) + 27 * int'(tern[3]);
  end

  assign result = lutRom[LUT_IDX_W'(idxSum)];

endmodule

// File: rtl/gev_datapath.sv
module gev_datapath
  import gev_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int INSTR_W = 5 * ADDR_W + 6
) (
  input  logic               clk,
  input  ctrl_strobe_t       strobe,
  input  logic [ADDR_W-1:0]  pc,
  input  logic               instWrEn,
  input  logic [ADDR_W-1:0]  instWrAddr,
  input  logic [INSTR_W-1:0] instWrData,
  input  logic               dataWrEn,
  input  logic [ADDR_W-1:0]  dataWrAddr,
  input  logic [1:0]         dataWrData,
  input  logic [ADDR_W-1:0]  dataRdAddr,
  output logic [1:0]         dataRdData
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int DST_LSB = 4 * ADDR_W;
  localparam int AR_LSB  = 5 * ADDR_W;
  localparam int FN_LSB  = 5 * ADDR_W + 2;

  logic [INSTR_W-1:0] instMem [DEPTH];
  logic [1:0]         dataMem [DEPTH];

  logic [INSTR_W-1:0] curInst;
  logic [3:0]         funcCode;
  logic [1:0]         arity;
  logic [ADDR_W-1:0]  dstAddr;
  logic [3:0][1:0]    opVals;
  logic [1:0]         gateOut;

  assign curInst  = instMem[pc];
  assign funcCode = curInst[FN_LSB +: 4];
  assign arity    = curInst[AR_LSB +: 2];
  assign dstAddr  = curInst[DST_LSB +: ADDR_W];

  for (genvar s = 0; s < 4; s++) begin : gFetch
    assign opVals[s] = dataMem[curInst[s*ADDR_W +: ADDR_W]];
  end

  gev_eval evalUnit (
    .funcCode (funcCode),
    .arity    (arity),
    .opVals   (opVals),
    .result   (gateOut)
  );

  always_ff @(posedge clk) begin
    if (strobe.hostEn && instWrEn) instMem[instWrAddr] <= instWrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.evalEn)                  dataMem[dstAddr]    <= gateOut;
    else if (strobe.hostEn && dataWrEn) dataMem[dataWrAddr] <= dataWrData;
  end

  assign dataRdData = dataMem[dataRdAddr];

endmodule

// File: rtl/gate_eval_unit.sv
module gate_eval_unit
  import gev_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int INSTR_W = 5 * ADDR_W + 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W:0]    gateCount,
  output logic               busy,
  output logic               done,
  input  logic               instWrEn,
  input  logic [ADDR_W-1:0]  instWrAddr,
  input  logic [INSTR_W-1:0] instWrData,
  input  logic               dataWrEn,
  input  logic [ADDR_W-1:0]  dataWrAddr,
  input  logic [1:0]         dataWrData,
  input  logic [ADDR_W-1:0]  dataRdAddr,
  output logic [1:0]         dataRdData
);

  ctrl_strobe_t      strobe;
  logic [ADDR_W-1:0] pc;

  gev_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .gateCount (gateCount),
    .pc        (pc),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  gev_datapath #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) dpath (
    .clk        (clk),
    .strobe     (strobe),
    .pc         (pc),
    .instWrEn   (instWrEn),
    .instWrAddr (instWrAddr),
    .instWrData (instWrData),
    .dataWrEn   (dataWrEn),
    .dataWrAddr (dataWrAddr),
    .dataWrData (dataWrData),
    .dataRdAddr (dataRdAddr),
    .dataRdData (dataRdData)
  );

endmodule

// File: rtl/gev_checker.sv
module gev_checker #(
  parameter int ADDR_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [ADDR_W:0] gateCount,
  input logic            busy,
  input logic            done
);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_done_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done && gateCount != '0) |=> busy);

  assert_busy_ends_in_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done && gateCount == '0) |=> (done && !busy));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

endmodule

bind gate_eval_unit gev_checker #(.ADDR_W(ADDR_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .gateCount (gateCount),
  .busy      (busy),
  .done      (done)
);

// File: tb/gate_eval_unit_test.sv
module gate_eval_unit_test;

  localparam int AW = 12;
  localparam int IW = 5 * AW + 6;
  localparam int NSIG = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW:0] gateCount = '0;
  logic busy, done;
  logic instWrEn = 1'b0;
  logic [AW-1:0] instWrAddr = '0;
  logic [IW-1:0] instWrData = '0;
  logic dataWrEn = 1'b0;
  logic [AW-1:0] dataWrAddr = '0;
  logic [1:0] dataWrData = '0;
  logic [AW-1:0] dataRdAddr = '0;
  logic [1:0] dataRdData;

  gate_eval_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .gateCount(gateCount),
    .busy(busy), .done(done),
    .instWrEn(instWrEn), .instWrAddr(instWrAddr), .instWrData(instWrData),
    .dataWrEn(dataWrEn), .dataWrAddr(dataWrAddr), .dataWrData(dataWrData),
    .dataRdAddr(dataRdAddr), .dataRdData(dataRdData)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Bench-side program and signal model
  int pFn [NSIG];
  int pAr [NSIG];
  int pDst [NSIG];
  int pS0 [NSIG];
  int pS1 [NSIG];
  int pS2 [NSIG];
  int pS3 [NSIG];
  logic [1:0] mdl [NSIG];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] flip(input logic [1:0] v);
    case (v)
      2'b00: return 2'b01;
      2'b01: return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] benchGate(input int fn, input int ar,
      input logic [1:0] a, input logic [1:0] b, input logic [1:0] c, input logic [1:0] d);
    logic [1:0] v [4];
    int zeros, ones, unks;
    logic [1:0] r;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    for (int i = 0; i < 4; i++) if (v[i] == 2'b11) v[i] = 2'b10;
    if (fn >= 8) v[0] = flip(v[0]);
    zeros = 0; ones = 0; unks = 0;
    for (int i = 0; i <= ar; i++) begin
      if (v[i] == 2'b00) zeros++;
      else if (v[i] == 2'b01) ones++;
      else unks++;
    end
    case (fn % 4)
      0: r = (zeros > 0) ? 2'b00 : ((unks > 0) ? 2'b10 : 2'b01);
      1: r = (ones > 0) ? 2'b01 : ((unks > 0) ? 2'b10 : 2'b00);
      2: r = (unks > 0) ? 2'b10 : ((ones % 2 == 1) ? 2'b01 : 2'b00);
      default: r = v[0];
    endcase
    if ((fn / 4) % 2 == 1) r = flip(r);
    return r;
  endfunction

  task automatic writeInst(input int idx, input int fn, input int ar, input int dst,
                           input int s0, input int s1, input int s2, input int s3);
    pFn[idx] = fn; pAr[idx] = ar; pDst[idx] = dst;
    pS0[idx] = s0; pS1[idx] = s1; pS2[idx] = s2; pS3[idx] = s3;
    @(negedge clk);
    instWrEn = 1'b1;
    instWrAddr = AW'(idx);
    instWrData = {4'(fn), 2'(ar), AW'(dst), AW'(s3), AW'(s2), AW'(s1), AW'(s0)};
    @(negedge clk);
    instWrEn = 1'b0;
  endtask

  task automatic writeSig(input int addr, input logic [1:0] val);
    mdl[addr] = val;
    @(negedge clk);
    dataWrEn = 1'b1;
    dataWrAddr = AW'(addr);
    dataWrData = val;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic runModel(input int n);
    for (int g = 0; g < n; g++)
      mdl[pDst[g]] = benchGate(pFn[g], pAr[g], mdl[pS0[g]], mdl[pS1[g]], mdl[pS2[g]], mdl[pS3[g]]);
  endtask

  // Runs a pass of n gates; optional host interference while busy (R9).
  task automatic runPass(input int n, input bit poke, input int pokeAddr);
    int edgesSeen;
    @(negedge clk);
    start = 1'b1;
    gateCount = (AW+1)'(n);
    @(negedge clk);
    start = 1'b0;
    check(busy == (n > 0), "R2 busy after start", int'(busy), int'(n > 0));
    edgesSeen = 0;
    while (!done && edgesSeen < n + 5) begin
      if (poke && edgesSeen == 2) begin
        dataWrEn = 1'b1; dataWrAddr = AW'(pokeAddr); dataWrData = 2'b11;
        instWrEn = 1'b1; instWrAddr = '0; instWrData = '0;
        start = 1'b1; gateCount = (AW+1)'(1);
      end
      @(negedge clk);
      dataWrEn = 1'b0; instWrEn = 1'b0; start = 1'b0;
      edgesSeen++;
    end
    check(edgesSeen == n, "R2 done latency", edgesSeen, n);
    check(!busy, "R2 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R2 done single cycle", int'(done), 0);
    runModel(n);
  endtask

  task automatic checkSig(input int addr, input logic [1:0] exp, input string req);
    dataRdAddr = AW'(addr);
    #1;
    check(dataRdData === exp, req, int'(dataRdData), int'(exp));
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset state", int'({busy, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);

    // Directed corner cases
    writeSig(0, 2'b00); writeSig(1, 2'b01); writeSig(2, 2'b10); writeSig(3, 2'b11);
    checkSig(3, 2'b11, "R10 readback of Z");
    writeInst(0, 0, 3, 100, 1, 1, 3, 1);   // AND with Z -> X
    writeInst(1, 1, 1, 101, 2, 1, 0, 0);   // OR X,1 -> 1
    writeInst(2, 0, 1, 102, 0, 2, 0, 0);   // AND 0,X -> 0
    writeInst(3, 2, 2, 103, 1, 1, 1, 0);   // XOR 1,1,1 -> 1
    writeInst(4, 14, 1, 104, 1, 0, 0, 0);  // XNOR with first inverted: ~(0^0) -> 1
    writeInst(5, 7, 0, 105, 3, 0, 0, 0);   // inverted BUF of Z -> X
    writeInst(6, 0, 0, 106, 1, 0, 0, 0);   // AND arity 0, unused slots point at 0 -> 1
    writeInst(7, 1, 0, 107, 0, 1, 1, 1);   // OR arity 0, unused slots point at 1 -> 0
    writeInst(8, 11, 0, 108, 106, 0, 0, 0);// BUF, first inverted, reads gate 6 result -> 0
    writeInst(9, 4, 1, 109, 0, 2, 0, 0);   // NAND 0,X -> 1
    runPass(10, 1'b0, 0);
    checkSig(100, 2'b10, "R3 Z input treated as X in AND");
    checkSig(101, 2'b01, "R5 OR with 1 dominates X");
    checkSig(102, 2'b00, "R5 AND with 0 dominates X");
    checkSig(103, 2'b01, "R5 XOR parity of three ones");
    checkSig(104, 2'b01, "R4 invert output and first input");
    checkSig(105, 2'b10, "R4 inverted BUF of Z gives X");
    checkSig(106, 2'b01, "R6 AND unused slots ignored");
    checkSig(107, 2'b00, "R6 OR unused slots ignored");
    checkSig(108, 2'b00, "R7 later gate sees earlier write");
    checkSig(109, 2'b01, "R4 NAND via output inversion");

    // Zero gate count
    writeSig(110, 2'b01);
    runPass(0, 1'b0, 0);
    checkSig(110, 2'b01, "R8 zero count leaves signals unchanged");

    // Host writes and start ignored while busy
    writeInst(0, 1, 1, 300, 1, 0, 0, 0);
    writeInst(1, 0, 1, 301, 1, 1, 0, 0);
    writeInst(2, 2, 1, 302, 1, 0, 0, 0);
    writeInst(3, 3, 0, 303, 2, 0, 0, 0);
    writeInst(4, 12, 1, 304, 0, 1, 0, 0);
    runPass(5, 1'b1, 300);
    checkSig(300, mdl[300], "R9 data write ignored while busy");
    checkSig(304, mdl[304], "R9 pass completes after ignored start");
    writeSig(300, 2'b10);
    runPass(5, 1'b0, 0);
    checkSig(300, mdl[300], "R9 gate entry write ignored while busy");

    // Random passes
    for (int pass = 0; pass < 20; pass++) begin
      int n;
      for (int a = 0; a < 512; a++) mdl[a] = 2'($urandom % 4);
      for (int a = 0; a < 512; a += 1) begin
        @(negedge clk);
        dataWrEn = 1'b1; dataWrAddr = AW'(a); dataWrData = mdl[a];
      end
      @(negedge clk);
      dataWrEn = 1'b0;
      for (int a = 512; a < 768; a++) writeSig(a, 2'($urandom % 4));
      n = 1 + int'($urandom % 40);
      for (int g = 0; g < n; g++)
        writeInst(g, int'($urandom % 16), int'($urandom % 4), 512 + int'($urandom % 256),
                  int'($urandom % 768), int'($urandom % 768),
                  int'($urandom % 768), int'($urandom % 768));
      runPass(n, 1'b0, 0);
      for (int a = 512; a < 768; a++) checkSig(a, mdl[a], "R5 random pass signal value");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule